// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns an I/O bus address into a real memory address by walking two tables that software keeps in memory. The upper bits of the I/O address select one descriptor in a segment table; each segment covers 256 MB. That descriptor says whether the segment is usable, where its page array lives, how many 4 KB pages of page entries it owns, and which page size it uses. The walker then fetches one page entry and checks it against the direction of the access. It returns either the translated address with the entry's ordering flag and device tag, or a fault code.

Because page size is chosen per segment, the number of page-index bits taken from the I/O address changes from one segment to the next: 16 bits for 4 KB pages, down to 4 bits for 16 MB pages. Two externally held registers control the block: a table origin word, which carries the segment table base and an enable bit, and a configuration word, which carries a global translation-enable bit. When either bit is clear, addresses pass through untranslated. Table memory is reached through a read port that allows only one read outstanding at a time. The walker handles one request at a time.

Top module: `io_xlate_walker`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` and `mem_req` are 0 and `req_ready` is 1.
- R2: When `tbl_origin[63]` or `xlate_cfg[47]` is 0 at acceptance, the next cycle returns `rsp_addr` equal to the zero-extended request address, with fault code 0, tag 0 and ordering flag 0. No table read is made.
- R3: The segment descriptor is read at `{tbl_origin[RA_W-1:12], 12'h000} + 8 * req_addr[IOA_W-1:28]`. Bit 11 and the other low bits of the origin word do not change this address.
- R4: A descriptor with bit 63 clear ends the walk with fault code 1 (segment fault). No page entry is read.
- R5: Descriptor bits 2:0 select the page size: 1 gives a 4 KB shift of 12, 3 gives 16, 5 gives 20 and 7 gives 24. Any code with bit 0 clear ends the walk with fault code 1.
- R6: The page index is `req_addr[27:shift]`. The page entry is read at `{desc[RA_W-1:12], 12'h000} + 8 * index`.
- R7: If the page index is at least `(desc[11:5] + 1) * 512`, the walk ends with fault code 2 (page fault). No page entry is read.
- R8: A page entry carries a write permit in bit 63, a read permit in bit 62, a strong-ordering flag in bit 61, an 11-bit tag in bits 10:0 and the real page in bits RA_W-1:12. A good result is the entry's bits RA_W-1:shift joined with `req_addr[shift-1:0]`, together with the tag and the flag.
- R9: A write whose entry lacks bit 63, or a read whose entry lacks bit 62, ends with fault code 2.
- R10: Every faulting response reports `rsp_addr`, `rsp_ioid` and `rsp_strong` as 0. Fault code 3 never appears.
- R11: `mem_req` lasts one cycle, and no further read is issued until `mem_rvalid` returns. `rsp_valid` lasts one cycle, and no new request is accepted during a walk.
- R12: Descriptor bit 62 (the caching hint) has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_origin | input | 64 | Segment table base (bits RA_W-1:12) and enable (bit 63) |
| xlate_cfg | input | 64 | Global translation enable in bit 47 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_addr | input | IOA_W | I/O address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_addr | output | RA_W | Real address, or 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 segment fault, 2 page fault |
| rsp_ioid | output | 11 | Tag taken from the page entry |
| rsp_strong | output | 1 | Strong-ordering flag from the page entry |
| mem_req | output | 1 | One-cycle table read request |
| mem_addr | output | RA_W | Byte address of the 64-bit table word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Table word returned |

## Verification
The bench goes after the segment-dependent index width. It uses one segment of each page size, including the largest index a 512-entry array allows and the largest a 128-page array allows. A walker that took a fixed number of index bits would fetch the wrong entry, and the result would not match. The bench also uses indices exactly one past the array length; a walker with an off-by-one limit would read a page entry in that case, and the read count would expose it. The origin word has bit 11 set throughout, so a base taken from the wrong bits reads an empty descriptor and faults. Direction checks use read-only and write-only entries, so a swapped permit bit turns a good result into a fault. The page entry carries low bits below the large-page boundary, so a result that merged the entry with the offset incorrectly would show the wrong address.

// File: rtl/io_xlate_walker.sv
module io_xlate_walker #(
  parameter int IOA_W = 32,
  parameter int RA_W  = 42,
  parameter int ID_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      tbl_origin,
  input  logic [63:0]      xlate_cfg,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IOA_W-1:0] req_addr,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [RA_W-1:0]  rsp_addr,
  output logic [1:0]       rsp_fault,
  output logic [ID_W-1:0]  rsp_ioid,
  output logic             rsp_strong,
  output logic             mem_req,
  output logic [RA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [63:0]      mem_rdata
);
  localparam int SEG_W = IOA_W - 28;
  localparam int IDX_W = 28 - 12;
  localparam int LIM_W = IDX_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_STE_RD, S_STE_WT, S_PTE_RD, S_PTE_WT, S_RESP} st_t;

  st_t               st;
  logic [IOA_W-1:0]  a_q;
  logic              wr_q;
  logic [RA_W-13:0]  pt_q;
  logic [1:0]        sz_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RA_W-1:0]   res_addr;
  logic [1:0]        res_flt;
  logic [ID_W-1:0]   res_id;
  logic              res_so;

  wire xl_on = tbl_origin[63] & xlate_cfg[47];
  wire accept = req_valid & (st == S_IDLE);

  wire [2:0]       ps      = mem_rdata[2:0];
  wire [4:0]       ste_sh  = 5'd12 + {1'b0, ps[2:1], 2'b00};
  wire [27:0]      ste_idx = a_q[27:0] >> ste_sh;
  wire [7:0]       npp1    = {1'b0, mem_rdata[11:5]} + 8'd1;
  wire [LIM_W-1:0] ste_lim = {npp1, 9'd0};
  wire             seg_bad = !mem_rdata[63] || !ps[0];
  wire             idx_bad = ste_idx >= {{(28-LIM_W){1'b0}}, ste_lim};

  wire [4:0]      pte_sh  = 5'd12 + {1'b0, sz_q, 2'b00};
  wire [RA_W-1:0] keep    = {RA_W{1'b1}} << pte_sh;
  wire [RA_W-1:0] off     = {{(RA_W-28){1'b0}}, a_q[27:0]};
  wire            perm_ok = wr_q ? mem_rdata[63] : mem_rdata[62];

  wire unused_bits = ^{mem_rdata[60:RA_W], tbl_origin[62:RA_W], tbl_origin[11:0],
                       xlate_cfg[63:48], xlate_cfg[46:0], ste_idx[27:IDX_W]};

  assign req_ready  = (st == S_IDLE);
  assign rsp_valid  = (st == S_RESP);
  assign rsp_addr   = res_addr;
  assign rsp_fault  = res_flt;
  assign rsp_ioid   = res_id;
  assign rsp_strong = res_so;
  assign mem_req    = (st == S_STE_RD) || (st == S_PTE_RD);
  assign mem_addr   = (st == S_PTE_RD)
    ? {pt_q, 12'd0} + {{(RA_W-IDX_W-3){1'b0}}, idx_q, 3'd0}
    : {tbl_origin[RA_W-1:12], 12'd0} + {{(RA_W-SEG_W-3){1'b0}}, a_q[IOA_W-1:28], 3'd0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      a_q      <= '0;
      wr_q     <= 1'b0;
      pt_q     <= '0;
      sz_q     <= '0;
      idx_q    <= '0;
      res_addr <= '0;
      res_flt  <= '0;
      res_id   <= '0;
      res_so   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          a_q  <= req_addr;
          wr_q <= req_write;
          if (xl_on) st <= S_STE_RD;
          else begin
            res_addr <= {{(RA_W-IOA_W){1'b0}}, req_addr};
            res_flt  <= 2'd0;
            res_id   <= '0;
            res_so   <= 1'b0;
            st       <= S_RESP;
          end
        end
        S_STE_RD: st <= S_STE_WT;
        S_STE_WT: if (mem_rvalid) begin
          if (seg_bad || idx_bad) begin
            res_addr <= '0;
            res_flt  <= seg_bad ? 2'd1 : 2'd2;
            res_id   <= '0;
            res_so   <= 1'b0;
            st       <= S_RESP;
          end else begin
            pt_q  <= mem_rdata[RA_W-1:12];
            sz_q  <= ps[2:1];
            idx_q <= ste_idx[IDX_W-1:0];
            st    <= S_PTE_RD;
          end
        end
        S_PTE_RD: st <= S_PTE_WT;
        S_PTE_WT: if (mem_rvalid) begin
          if (!perm_ok) begin
            res_addr <= '0;
            res_flt  <= 2'd2;
            res_id   <= '0;
            res_so   <= 1'b0;
          end else begin
            res_addr <= (mem_rdata[RA_W-1:0] & keep) | (off & ~keep);
            res_flt  <= 2'd0;
            res_id   <= mem_rdata[ID_W-1:0];
            res_so   <= mem_rdata[61];
          end
          st <= S_RESP;
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(tbl_origin[63] && xlate_cfg[47])) |=>
    (rsp_valid && rsp_fault == 2'd0 && !mem_req)); // R2
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_addr == '0 && rsp_ioid == '0 && !rsp_strong)); // R10
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3); // R10
  AST_SEG_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STE_WT && mem_rvalid && !mem_rdata[63]) |=> (rsp_valid && rsp_fault == 2'd1)); // R4
endmodule

// File: tb/io_xlate_walker_test.sv
module io_xlate_walker_test;
  localparam int PERIOD = 10;
  localparam int IOA_W = 32;
  localparam int RA_W = 42;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [63:0] org = '0, cfg = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [IOA_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_strong, mem_req;
  logic [RA_W-1:0] rsp_addr, mem_addr;
  logic [1:0] rsp_fault;
  logic [10:0] rsp_ioid;
  logic mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #(PERIOD/2) clk = ~clk;

  io_xlate_walker #(.IOA_W(IOA_W), .RA_W(RA_W), .ID_W(11)) uut (
    .clk(clk), .rst_n(rst_n), .tbl_origin(org), .xlate_cfg(cfg),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault), .rsp_ioid(rsp_ioid),
    .rsp_strong(rsp_strong), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  logic [63:0] mem [longint];
  int total = 0, bad = 0, cyc = 0, reads_seen = 0, nreads = 0;
  logic [63:0] q_addr[$];
  int q_flt[$], q_id[$], q_so[$], q_rd[$], q_cyc[$];
  string q_tag[$];
  longint amask;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] rd(longint a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] mk_ste(longint ptb, int npp, int ps, bit v, bit hint);
    return ({v, hint, 62'd0}) | (ptb & amask) | (64'(npp) << 5) | 64'(ps);
  endfunction

  function automatic logic [63:0] mk_pte(bit w, bit r, bit so, longint rpn, int id);
    return ({w, r, so, 61'd0}) | (rpn & amask) | 64'(id & 'h7FF);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] a, input bit wr, input string tag);
    logic [63:0] ste, pte, ea;
    int ef, er, eid, eso, sh;
    longint idx, lim;
    ea = 0; ef = 0; er = 0; eid = 0; eso = 0;
    if (!(org[63] && cfg[47])) ea = 64'(a);
    else begin
      ste = rd((longint'(org) & amask) + longint'(a >> 28) * 8);
      er = 1;
      if (!ste[63] || !ste[0]) ef = 1;
      else begin
        case (ste[2:0])
          3'd1: sh = 12;
          3'd3: sh = 16;
          3'd5: sh = 20;
          default: sh = 24;
        endcase
        idx = longint'(a & 32'h0FFF_FFFF) >> sh;
        lim = (longint'(ste[11:5]) + 1) * 512;
        if (idx >= lim) ef = 2;
        else begin
          pte = rd((longint'(ste) & amask) + idx * 8);
          er = 2;
          if (wr ? !pte[63] : !pte[62]) ef = 2;
          else begin
            ea = (pte & amask & ~((64'd1 << sh) - 1)) | (64'(a) & ((64'd1 << sh) - 1));
            eid = int'(pte[10:0]);
            eso = int'(pte[61]);
          end
        end
      end
    end
    @(negedge clk);
    while (req_ready !== 1'b1) @(negedge clk);
    req_addr = a; req_write = wr; req_valid = 1'b1;
    q_addr.push_back(ea); q_flt.push_back(ef); q_id.push_back(eid);
    q_so.push_back(eso); q_rd.push_back(er); q_cyc.push_back(cyc); q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // memory responder and response monitor, evaluated every cycle
  initial begin
    bit busy = 0;
    int wcnt = 0;
    longint paddr = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (busy) begin
        wcnt--;
        if (wcnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = rd(paddr);
          busy = 0;
        end
      end
      if (mem_req === 1'b1) begin
        chk(!busy, "R11", "read issued while one outstanding", 64'd1, 64'd0);
        busy = 1;
        nreads++;
        wcnt = 1 + (nreads % 3);
        paddr = longint'(mem_addr);
        reads_seen++;
      end
      if (rsp_valid === 1'b1) begin
        if (q_addr.size() == 0) chk(0, "R11", "response without request", 64'd1, 64'd0);
        else begin
          logic [63:0] ea;
          int ef, eid, eso, er, ec;
          string tg;
          ea = q_addr.pop_front(); ef = q_flt.pop_front(); eid = q_id.pop_front();
          eso = q_so.pop_front(); er = q_rd.pop_front(); ec = q_cyc.pop_front(); tg = q_tag.pop_front();
          chk(rsp_fault == 2'(ef), tg, "fault", 64'(rsp_fault), 64'(ef));
          chk(64'(rsp_addr) == ea, tg, "addr", 64'(rsp_addr), ea);
          chk(int'(rsp_ioid) == eid && int'(rsp_strong) == eso, tg, "ioid/strong",
              {rsp_ioid, 4'd0, 3'd0, rsp_strong}, 64'((eid << 8) | eso));
          chk(reads_seen == er, tg, "table reads", 64'(reads_seen), 64'(er));
          if (er == 0) chk(cyc - ec == 1, "R2", "bypass latency", 64'(cyc - ec), 64'd1);
          reads_seen = 0;
        end
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    total++; bad++;
    $display("FAIL R11 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    amask = ((longint'(1) << RA_W) - 1) & ~longint'('hFFF);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && mem_req == 0 && req_ready == 1, "R1", "reset outputs",
        {61'd0, rsp_valid, mem_req, req_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0 && mem_req == 0 && req_ready == 1, "R1", "after reset",
        {61'd0, rsp_valid, mem_req, req_ready}, 64'd1);

    // segment table at 0x100000, origin bit 11 set to catch a wrong base (R3)
    mem[64'h10_0000 + 0*8] = mk_ste(64'h20_0000, 0, 1, 1, 1);
    mem[64'h10_0000 + 1*8] = mk_ste(64'h30_0000, 1, 3, 1, 0);
    mem[64'h10_0000 + 2*8] = mk_ste(64'h40_0000, 0, 5, 1, 0);
    mem[64'h10_0000 + 3*8] = mk_ste(64'h50_0000, 0, 7, 1, 0);
    mem[64'h10_0000 + 4*8] = mk_ste(64'h60_0000, 0, 1, 0, 0);
    mem[64'h10_0000 + 5*8] = mk_ste(64'h60_0000, 0, 2, 1, 0);
    mem[64'h10_0000 + 7*8] = mk_ste(64'h100_0000, 127, 1, 1, 0);
    mem[64'h20_0000 + 0*8]   = mk_pte(1, 1, 0, 64'h3_0000_0000, 'h011);
    mem[64'h20_0000 + 5*8]   = mk_pte(0, 1, 1, 64'h555_5000, 'h7FF);
    mem[64'h20_0000 + 511*8] = mk_pte(1, 0, 0, 64'hABCD_E000, 0);
    mem[64'h30_0000 + 3*8]   = mk_pte(1, 1, 1, 64'h1234_5000, 'h5A5);
    mem[64'h40_0000 + 255*8] = mk_pte(1, 1, 0, 64'h7_8900_0000, 'h123);
    mem[64'h50_0000 + 15*8]  = mk_pte(1, 1, 1, 64'h2A_5F00_0000, 'h042);
    mem[64'h100_0000 + 65535*8] = mk_pte(1, 1, 0, 64'h3FF_FFFF_F000, 'h3C3);

    // bypass
    org = 64'h10_0800; cfg = 64'h0000_8000_0000_0000;
    send(32'h1234_5678, 0, "R2");
    send(32'hFFFF_FFFF, 1, "R2");
    org = 64'h8000_0000_0010_0800; cfg = 64'd0;
    send(32'h0000_0010, 0, "R2");

    // translated
    cfg = 64'h0000_8000_0000_0000;
    send(32'h0000_0ABC, 0, "R3");
    send(32'h0000_0123, 1, "R12");
    send(32'h0000_5FFF, 0, "R9");
    send(32'h0000_5000, 1, "R9");
    send(32'h001F_F001, 1, "R6");
    send(32'h001F_F001, 0, "R9");
    send(32'h0020_0000, 0, "R7");
    send(32'h1003_ABCD, 1, "R8");
    send(32'h1400_0000, 0, "R7");
    send(32'h2FF1_2345, 0, "R5");
    send(32'h3F12_3456, 1, "R5");
    send(32'h4000_0000, 0, "R4");
    send(32'h5000_0000, 0, "R5");
    send(32'h6ABC_0000, 1, "R10");
    send(32'h7FFF_F123, 0, "R6");
    send(32'h79C4_0000, 0, "R9");

    // back to bypass after translating
    org = 64'h0000_0000_0010_0800;
    send(32'h3F12_3456, 1, "R2");

    while (q_addr.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule